// File: doc/BRIEF.md
# Wishbone Chained Output Register

This block is a Wishbone slave holding one output register whose contents drive a parallel output continuously. The register may be wider than the data bus. Its bits are placed in a flat address space made of bus words, starting at a chosen bit offset, so a wide register is reached through several addressed words and some word positions may hold no register bits at all. Writes are masked per byte lane. A read returns the register bits that fall in the addressed word.

Read data and acknowledge are merged with chain inputs, so several of these slaves can share one return path. Each slave ORs its own contribution into what it receives from the previous slave and passes the result on. The value loaded at reset comes from an input port. Each access completes in the cycle it is presented, with no wait states.

Top module: `wb_chain_outreg`

## Requirements
- R1: While `rst_i` is high at a rising edge of `clk_i`, the register loads `rst_val_i`. From the next cycle `q_o` shows that value.
- R2: `q_o` presents the register contents at all times. A selected write shows on `q_o` right after the rising edge that ends the write cycle.
- R3: When `cyc_i` and `stb_i` are both high, `ack_o` is high in the same cycle. Otherwise `ack_o` equals `ack_chain_i`.
- R4: Register bit i lives at flat position p = i + BIT_OFS. That is word p / BUS_W, bit p % BUS_W of that word. A selected read (`we_i` low) returns these bits in the word chosen by `adr_i`.
- R5: On a selected read, every bit position of the addressed word that holds no register bit reads as 0. Any address at or beyond the word count also reads as 0.
- R6: `dat_o` is the read word ORed with `dat_chain_i`. When there is no selected read (deselected, or a write), `dat_o` equals `dat_chain_i`.
- R7: On a selected write, a register bit is updated from `dat_i` only when its word equals `adr_i` and its byte lane is enabled. Lane j covers word bits 8j to 8j+7 and is enabled by `sel_i[j]`. Every other register bit keeps its value, and a write with `sel_i` all zero changes nothing.
- R8: Without a selected write (`cyc_i`, `stb_i` or `we_i` low), the register keeps its value.
- R9: Write data at word positions that hold no register bit is discarded and affects no register bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; the register updates on the rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| cyc_i | input | 1 | Bus cycle in progress |
| stb_i | input | 1 | Strobe to this slave |
| we_i | input | 1 | High for write, low for read |
| sel_i | input | BUS_W/8 | Byte lane enables |
| adr_i | input | ADDR_W | Word address inside the register space |
| dat_i | input | BUS_W | Write data |
| dat_o | output | BUS_W | Read data merged with chain data |
| ack_o | output | 1 | Acknowledge merged with chain acknowledge |
| ack_chain_i | input | 1 | Acknowledge from the previous slave in the chain |
| dat_chain_i | input | BUS_W | Read data from the previous slave in the chain |
| rst_val_i | input | REG_W | Value loaded at reset |
| q_o | output | REG_W | Register contents |

## Verification
A wrong register bit is visible on `q_o` in the cycle after the edge that stored it. It is also visible on `dat_o` in the same cycle as any read of its word. The reference model therefore compares `q_o`, `ack_o` and `dat_o` on every clock. A write with a wrong lane or word mapping is caught no later than one cycle after the write. A read-path mapping error is caught in the read cycle itself, and nonzero chain inputs expose any merge that drops or overrides the chain data.

// File: rtl/wbo_pkg.sv
package wbo_pkg;

  // Number of bus words needed to cover the offset plus the register
  function automatic int unsigned word_count(int unsigned reg_w, int unsigned ofs,
                                             int unsigned bus_w);
    return (reg_w + ofs + bus_w - 1) / bus_w;
  endfunction

  // Address bits for a given number of words (at least one)
  function automatic int unsigned addr_bits(int unsigned words);
    return (words <= 1) ? 1 : $clog2(words);
  endfunction

  // Word holding register bit idx
  function automatic int unsigned word_of(int unsigned idx, int unsigned ofs,
                                          int unsigned bus_w);
    return (idx + ofs) / bus_w;
  endfunction

  // Bit position inside its word of register bit idx
  function automatic int unsigned slot_of(int unsigned idx, int unsigned ofs,
                                          int unsigned bus_w);
    return (idx + ofs) % bus_w;
  endfunction

  // Register bit index seen at word w, slot k; negative or >= reg_w means none
  function automatic int reg_index(int unsigned w, int unsigned k, int unsigned ofs,
                                   int unsigned bus_w);
    return int'(w * bus_w + k) - int'(ofs);
  endfunction

endpackage

// File: rtl/wbo_decode.sv
module wbo_decode (
  input  logic cyc_i,
  input  logic stb_i,
  input  logic we_i,
  input  logic ack_chain_i,
  output logic sel_hit,
  output logic wr_hit,
  output logic rd_hit,
  output logic ack_o
);
  assign sel_hit = cyc_i & stb_i;
  assign wr_hit  = sel_hit & we_i;
  assign rd_hit  = sel_hit & ~we_i;
  assign ack_o   = sel_hit | ack_chain_i;
endmodule

// File: rtl/wbo_store.sv
module wbo_store #(
  parameter int unsigned REG_W  = 20,
  parameter int unsigned BUS_W  = 16,
  parameter int unsigned BIT_OFS = 4,
  parameter int unsigned ADDR_W = 1,
  parameter int unsigned LANES  = BUS_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wr_hit,
  input  logic [ADDR_W-1:0] adr_i,
  input  logic [LANES-1:0]  sel_i,
  input  logic [BUS_W-1:0]  dat_i,
  input  logic [REG_W-1:0]  rst_val_i,
  output logic [REG_W-1:0]  bit_we,
  output logic [REG_W-1:0]  q_o
);
  import wbo_pkg::*;

  for (genvar i = 0; i < REG_W; i++) begin : g_bit
    localparam int unsigned WORD = word_of(i, BIT_OFS, BUS_W);
    localparam int unsigned SLOT = slot_of(i, BIT_OFS, BUS_W);
    localparam int unsigned LANE = SLOT / 8;
    localparam logic [ADDR_W-1:0] WADR = ADDR_W'(WORD);

    assign bit_we[i] = wr_hit && (adr_i == WADR) && sel_i[LANE];

    always_ff @(posedge clk_i) begin
      if (rst_i)          q_o[i] <= rst_val_i[i];
      else if (bit_we[i]) q_o[i] <= dat_i[SLOT];
    end
  end
endmodule

// File: rtl/wbo_readback.sv
module wbo_readback #(
  parameter int unsigned REG_W  = 20,
  parameter int unsigned BUS_W  = 16,
  parameter int unsigned BIT_OFS = 4,
  parameter int unsigned ADDR_W = 1,
  parameter int unsigned WORDS  = 2
) (
  input  logic [REG_W-1:0]  q_i,
  input  logic [ADDR_W-1:0] adr_i,
  input  logic              rd_hit,
  input  logic [BUS_W-1:0]  dat_chain_i,
  output logic [BUS_W-1:0]  own_word,
  output logic [BUS_W-1:0]  dat_o
);
  import wbo_pkg::*;

  logic [WORDS-1:0][BUS_W-1:0] page;

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    for (genvar k = 0; k < BUS_W; k++) begin : g_slot
      localparam int IDX = reg_index(w, k, BIT_OFS, BUS_W);
      if (IDX >= 0 && IDX < int'(REG_W)) begin : g_live
        assign page[w][k] = q_i[IDX];
      end else begin : g_pad
        assign page[w][k] = 1'b0;
      end
    end
  end

  always_comb begin
    own_word = '0;
    if (32'(adr_i) < WORDS) own_word = page[adr_i];
  end

  assign dat_o = (rd_hit ? own_word : '0) | dat_chain_i;
endmodule

// File: rtl/wb_chain_outreg.sv
module wb_chain_outreg #(
  parameter int unsigned REG_W   = 20,
  parameter int unsigned BUS_W   = 16,
  parameter int unsigned BIT_OFS = 4,
  localparam int unsigned WORDS  = wbo_pkg::word_count(REG_W, BIT_OFS, BUS_W),
  localparam int unsigned ADDR_W = wbo_pkg::addr_bits(WORDS),
  localparam int unsigned LANES  = BUS_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              cyc_i,
  input  logic              stb_i,
  input  logic              we_i,
  input  logic [LANES-1:0]  sel_i,
  input  logic [ADDR_W-1:0] adr_i,
  input  logic [BUS_W-1:0]  dat_i,
  output logic [BUS_W-1:0]  dat_o,
  output logic              ack_o,
  input  logic              ack_chain_i,
  input  logic [BUS_W-1:0]  dat_chain_i,
  input  logic [REG_W-1:0]  rst_val_i,
  output logic [REG_W-1:0]  q_o
);
  // Named internal events, brought out for the checker
  logic             sel_hit;
  logic             wr_hit;
  logic             rd_hit;
  logic [REG_W-1:0] bit_we;
  logic [BUS_W-1:0] own_word;

  wbo_decode u_decode (
    .cyc_i       (cyc_i),
    .stb_i       (stb_i),
    .we_i        (we_i),
    .ack_chain_i (ack_chain_i),
    .sel_hit     (sel_hit),
    .wr_hit      (wr_hit),
    .rd_hit      (rd_hit),
    .ack_o       (ack_o)
  );

  wbo_store #(
    .REG_W(REG_W), .BUS_W(BUS_W), .BIT_OFS(BIT_OFS), .ADDR_W(ADDR_W), .LANES(LANES)
  ) u_store (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .wr_hit    (wr_hit),
    .adr_i     (adr_i),
    .sel_i     (sel_i),
    .dat_i     (dat_i),
    .rst_val_i (rst_val_i),
    .bit_we    (bit_we),
    .q_o       (q_o)
  );

  wbo_readback #(
    .REG_W(REG_W), .BUS_W(BUS_W), .BIT_OFS(BIT_OFS), .ADDR_W(ADDR_W), .WORDS(WORDS)
  ) u_read (
    .q_i         (q_o),
    .adr_i       (adr_i),
    .rd_hit      (rd_hit),
    .dat_chain_i (dat_chain_i),
    .own_word    (own_word),
    .dat_o       (dat_o)
  );
endmodule

// File: rtl/wbo_outreg_chk.sv
module wbo_outreg_chk #(
  parameter int unsigned REG_W  = 20,
  parameter int unsigned BUS_W  = 16,
  parameter int unsigned ADDR_W = 1,
  parameter int unsigned LANES  = 2
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic              cyc_i,
  input logic              stb_i,
  input logic              we_i,
  input logic [LANES-1:0]  sel_i,
  input logic [BUS_W-1:0]  dat_o,
  input logic              ack_o,
  input logic              ack_chain_i,
  input logic [BUS_W-1:0]  dat_chain_i,
  input logic [REG_W-1:0]  rst_val_i,
  input logic [REG_W-1:0]  q_o,
  input logic [REG_W-1:0]  bit_we
);
  AST_RESET_LOAD: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(rst_i) |-> q_o == $past(rst_val_i)); // R1

  AST_ACK_SELECTED: assert property (@(posedge clk_i) disable iff (rst_i)
    (cyc_i && stb_i) |-> ack_o); // R3

  AST_ACK_FORWARD: assert property (@(posedge clk_i) disable iff (rst_i)
    !(cyc_i && stb_i) |-> ack_o == ack_chain_i); // R3

  AST_DATA_FORWARD: assert property (@(posedge clk_i) disable iff (rst_i)
    !(cyc_i && stb_i && !we_i) |-> dat_o == dat_chain_i); // R6

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (rst_i)
    (!rst_i && !(cyc_i && stb_i && we_i)) |=> $stable(q_o)); // R8

  AST_NO_LANE_NO_CHANGE: assert property (@(posedge clk_i) disable iff (rst_i)
    (!rst_i && cyc_i && stb_i && we_i && sel_i == '0) |=> $stable(q_o)); // R7

  AST_STROBE_GATES_WRITE: assert property (@(posedge clk_i) disable iff (rst_i)
    !(cyc_i && stb_i && we_i) |-> bit_we == '0); // R8
endmodule

bind wb_chain_outreg wbo_outreg_chk #(
  .REG_W(REG_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W), .LANES(LANES)
) u_chk (
  .clk_i       (clk_i),
  .rst_i       (rst_i),
  .cyc_i       (cyc_i),
  .stb_i       (stb_i),
  .we_i        (we_i),
  .sel_i       (sel_i),
  .dat_o       (dat_o),
  .ack_o       (ack_o),
  .ack_chain_i (ack_chain_i),
  .dat_chain_i (dat_chain_i),
  .rst_val_i   (rst_val_i),
  .q_o         (q_o),
  .bit_we      (bit_we)
);

// File: tb/wb_chain_outreg_test.sv
`timescale 1ns/1ps
module wb_chain_outreg_test;
  localparam int RW = 20;
  localparam int BW = 16;
  localparam int OF = 4;
  localparam int NW = (RW + OF + BW - 1) / BW;
  localparam int AW = (NW <= 1) ? 1 : $clog2(NW);
  localparam int LN = BW / 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst = 1'b1, cyc = 1'b0, stb = 1'b0, we = 1'b0, ackc = 1'b0;
  logic [LN-1:0] sel = '0;
  logic [AW-1:0] adr = '0;
  logic [BW-1:0] din = '0, datc = '0;
  logic [RW-1:0] rval = 20'hA5C3E;
  logic [BW-1:0] dout;
  logic          ack;
  logic [RW-1:0] q;

  int checks = 0;
  int fails  = 0;
  logic [RW-1:0] model = '0;
  bit model_valid = 1'b0;

  wb_chain_outreg #(.REG_W(RW), .BUS_W(BW), .BIT_OFS(OF)) uut (
    .clk_i(clk), .rst_i(rst), .cyc_i(cyc), .stb_i(stb), .we_i(we), .sel_i(sel),
    .adr_i(adr), .dat_i(din), .dat_o(dout), .ack_o(ack), .ack_chain_i(ackc),
    .dat_chain_i(datc), .rst_val_i(rval), .q_o(q)
  );

  function automatic logic [BW-1:0] expect_read();
    logic [BW-1:0] r = '0;
    if (cyc && stb && !we) begin
      for (int k = 0; k < BW; k++) begin
        int gpos = int'(adr) * BW + k;
        if (gpos >= OF && gpos < OF + RW) r[k] = model[gpos - OF];
      end
    end
    return r | datc;
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  // Compare outputs away from the edge, then advance one clock and update the model
  task automatic step(string tag);
    #1;
    if (model_valid) check(tag, "q_o", 32'(q), 32'(model));
    check(tag, "ack_o", 32'(ack), 32'((cyc && stb) || ackc));
    check(tag, "dat_o", 32'(dout), 32'(expect_read()));
    @(posedge clk);
    if (rst) begin
      model = rval;
      model_valid = 1'b1;
    end else if (cyc && stb && we) begin
      for (int i = 0; i < RW; i++) begin
        int gpos = i + OF;
        if (int'(adr) == gpos / BW && sel[(gpos % BW) / 8]) model[i] = din[gpos % BW];
      end
    end
    #1;
  endtask

  task automatic bus(logic c, logic s, logic w, logic [AW-1:0] a, logic [LN-1:0] bs,
                     logic [BW-1:0] d, string tag);
    cyc = c; stb = s; we = w; adr = a; sel = bs; din = d;
    step(tag);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : stim
    @(posedge clk); #1;
    step("R1");
    step("R1");
    rst = 1'b0;
    check("R1", "q_o after reset", 32'(q), 32'(20'hA5C3E));
    // R2: q_o shows the reset value, reads see it too
    bus(1, 1, 0, 0, '0, '0, "R4");
    bus(1, 1, 0, 1, '0, '0, "R5");
    // R8: idle and partial strobes leave the register alone
    bus(0, 1, 1, 0, 2'b11, 16'h1234, "R8");
    bus(1, 0, 1, 1, 2'b11, 16'hFFFF, "R8");
    bus(0, 0, 1, 0, 2'b11, 16'h0000, "R8");
    // R7: full write to word 0, then single lanes of word 1
    bus(1, 1, 1, 0, 2'b11, 16'hBEEF, "R7");
    bus(1, 1, 0, 0, '0, '0, "R2");
    bus(1, 1, 1, 1, 2'b01, 16'hFF5A, "R7");
    bus(1, 1, 1, 1, 2'b10, 16'hFFFF, "R9");
    bus(1, 1, 1, 0, 2'b00, 16'h0000, "R7");
    check("R2", "q_o after writes", 32'(q), 32'(model));
    // R9: write of word-0 low nibble (no register bits there)
    bus(1, 1, 1, 0, 2'b01, 16'h000F, "R9");
    bus(1, 1, 0, 0, '0, '0, "R5");
    // R6: chain merge on read, on write and deselected
    datc = 16'h8001;
    bus(1, 1, 0, 1, '0, '0, "R6");
    bus(1, 1, 1, 1, 2'b00, 16'h0000, "R6");
    bus(0, 0, 0, 0, '0, '0, "R6");
    datc = '0;
    // R3: chain acknowledge alone and together with a select
    ackc = 1'b1;
    bus(0, 0, 0, 0, '0, '0, "R3");
    bus(1, 1, 0, 0, '0, '0, "R3");
    ackc = 1'b0;
    bus(1, 0, 0, 0, '0, '0, "R3");
    // Block write and read-modify-write as back-to-back cycles
    bus(1, 1, 1, 0, 2'b11, 16'h0F0F, "R7");
    bus(1, 1, 1, 1, 2'b11, 16'h00C3, "R7");
    bus(1, 1, 0, 1, '0, '0, "R4");
    bus(1, 1, 1, 1, 2'b01, dout ^ 16'h0011, "R7");
    // Mixed traffic
    for (int n = 0; n < 400; n++) begin
      ackc = ($urandom_range(0, 7) == 0);
      datc = ($urandom_range(0, 3) == 0) ? BW'($urandom) : '0;
      bus(1'($urandom), 1'($urandom), 1'($urandom), AW'($urandom), LN'($urandom),
          BW'($urandom), "R4");
    end
    ackc = 1'b0; datc = '0;
    // R1: reset in the middle of traffic with a new value
    rval = 20'h0137C;
    rst = 1'b1;
    bus(1, 1, 1, 0, 2'b11, 16'hFFFF, "R1");
    rst = 1'b0;
    bus(0, 0, 0, 0, '0, '0, "R1");
    check("R1", "q_o after second reset", 32'(q), 32'(20'h0137C));
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule